// File: doc/BRIEF.md
# Sample-only boundary-scan test port

This block is the serial test-access logic for a memory device that supports only part of the usual boundary-scan command set. A host drives a test clock, a mode-select line and a serial data input. The block then walks a sixteen-state control machine, loads a three-bit instruction and routes one of three data paths between the serial input and the serial output. The three paths are a one-bit bypass stage, a fixed 32-bit identity word and a capture-only boundary chain.

The boundary chain only takes a parallel snapshot of the device pins and shifts it out. It has no preload or update stage, so it can never drive a pin. Two instructions raise an output-float request that tells the surrounding device to place its outputs in high impedance. The serial output is launched on the falling edge of the test clock, and a separate enable marks when it is valid.

Top module: `scan_tap`

## Requirements
- R1: The instruction is 3 bits wide. Code 000 selects sample-with-float, 001 selects the identity word, 010 selects float-and-sample, 100 selects plain sample and 111 selects bypass. The codes 011, 101 and 110 are reserved and use the one-bit bypass path.
- R2: On every instruction capture, the instruction shift stage is loaded with 001, so the first three bits that appear on `tdo` are 1, 0, 0.
- R3: When `trst_n` is low, and whenever the controller is in its test-logic-reset state, the active instruction is the identity code 001 and `float_o` is low. Five rising edges with `tms` high reach that state from any state.
- R4: A newly shifted instruction has no effect on `float_o` or on the selected data path until the controller passes through its instruction-update state.
- R5: The bypass path captures 0 and then delays `tdi` by exactly one shift cycle.
- R6: Under the identity instruction, a data capture loads `ID_VAL`, and `ID_VAL` is shifted out least significant bit first.
- R7: Under codes 000, 010 and 100, a data capture loads `pins_i` into the boundary chain. `pins_i[0]` leaves on `tdo` first, and `tdi` enters at the most significant end.
- R8: `float_o` is high exactly when the active instruction is 000 or 010.
- R9: The data-update state has no effect. `float_o` does not change, and the next capture shows the current `pins_i` value rather than the bits that were shifted in.
- R10: `tdo` changes only on the falling edge of `tck`. `tdo_oe` is high only in the two shift states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low (tie high if unused) |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| pins_i | input | BSR_LEN | Parallel snapshot of the device input and bidirectional pins |
| tdo | output | 1 | Serial data out, launched on the falling edge |
| tdo_oe | output | 1 | High while `tdo` carries valid shift data |
| float_o | output | 1 | Request to place the device outputs in high impedance |

## Verification
In every shift cycle, two things fall in the same clock period. The rising edge shifts a new `tdi` bit into the chain, and the falling edge presents the next outgoing bit. The bench pushes every expected `tdo` bit into a queue. It samples `tdo` after each falling edge, then samples it again just after the following rising edge to confirm that the shift did not disturb it. The bench also sends a float instruction through the instruction path and then samples `float_o` in the exit state just before the update, so that instruction shifting and instruction taking effect are judged separately.

// File: rtl/scan_tap.sv
module scan_tap #(
  parameter int          BSR_LEN = 73,
  parameter logic [31:0] ID_VAL  = 32'h2F81_4093
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins_i,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               float_o
);

  typedef enum logic [3:0] {
    TLR    = 4'd0,  RTI    = 4'd1,  SEL_DR = 4'd2,  CAP_DR = 4'd3,
    SH_DR  = 4'd4,  EX1_DR = 4'd5,  PAU_DR = 4'd6,  EX2_DR = 4'd7,
    UPD_DR = 4'd8,  SEL_IR = 4'd9,  CAP_IR = 4'd10, SH_IR  = 4'd11,
    EX1_IR = 4'd12, PAU_IR = 4'd13, EX2_IR = 4'd14, UPD_IR = 4'd15
  } tap_t;

  localparam logic [2:0] OP_XSAMP = 3'b000;
  localparam logic [2:0] OP_IDENT = 3'b001;
  localparam logic [2:0] OP_FSAMP = 3'b010;
  localparam logic [2:0] OP_SAMP  = 3'b100;

  tap_t state, nxt;
  logic [2:0] ir, ir_sh;
  logic [31:0] id_sh;
  logic [BSR_LEN-1:0] bsr;
  logic byp;
  logic sel_id, sel_bsr, sel_byp;

  assign sel_id  = (ir == OP_IDENT);
  assign sel_bsr = (ir == OP_XSAMP) || (ir == OP_FSAMP) || (ir == OP_SAMP);
  assign sel_byp = !sel_id && !sel_bsr;
  assign float_o = (ir == OP_XSAMP) || (ir == OP_FSAMP);

  always_comb begin
    unique case (state)
      TLR:    nxt = tms ? TLR    : RTI;
      RTI:    nxt = tms ? SEL_DR : RTI;
      SEL_DR: nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR: nxt = tms ? EX1_DR : SH_DR;
      SH_DR:  nxt = tms ? EX1_DR : SH_DR;
      EX1_DR: nxt = tms ? UPD_DR : PAU_DR;
      PAU_DR: nxt = tms ? EX2_DR : PAU_DR;
      EX2_DR: nxt = tms ? UPD_DR : SH_DR;
      UPD_DR: nxt = tms ? SEL_DR : RTI;
      SEL_IR: nxt = tms ? TLR    : CAP_IR;
      CAP_IR: nxt = tms ? EX1_IR : SH_IR;
      SH_IR:  nxt = tms ? EX1_IR : SH_IR;
      EX1_IR: nxt = tms ? UPD_IR : PAU_IR;
      PAU_IR: nxt = tms ? EX2_IR : PAU_IR;
      EX2_IR: nxt = tms ? UPD_IR : SH_IR;
      UPD_IR: nxt = tms ? SEL_DR : RTI;
      default: nxt = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state <= TLR;
      ir    <= OP_IDENT;
      ir_sh <= 3'b000;
    end else begin
      state <= nxt;
      if (nxt == TLR)            ir <= OP_IDENT;
      else if (state == UPD_IR)  ir <= ir_sh;
      if (state == CAP_IR)       ir_sh <= 3'b001;
      else if (state == SH_IR)   ir_sh <= {tdi, ir_sh[2:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sh <= '0;
      bsr   <= '0;
      byp   <= 1'b0;
    end else if (state == CAP_DR) begin
      if (sel_id)  id_sh <= ID_VAL;
      if (sel_bsr) bsr   <= pins_i;
      if (sel_byp) byp   <= 1'b0;
    end else if (state == SH_DR) begin
      if (sel_id)  id_sh <= {tdi, id_sh[31:1]};
      if (sel_bsr) bsr   <= {tdi, bsr[BSR_LEN-1:1]};
      if (sel_byp) byp   <= tdi;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == SH_IR) || (state == SH_DR);
      if (state == SH_IR)  tdo <= ir_sh[0];
      else if (sel_id)     tdo <= id_sh[0];
      else if (sel_bsr)    tdo <= bsr[0];
      else                 tdo <= byp;
    end
  end

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk (
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input logic [3:0] state,
  input logic [2:0] ir,
  input logic [2:0] ir_sh,
  input logic       byp,
  input logic       sel_byp,
  input logic       tdo_oe,
  input logic       float_o
);
  localparam logic [3:0] S_TLR = 4'd0, S_CAP_DR = 4'd3, S_SH_DR = 4'd4,
                         S_SEL_IR = 4'd9, S_CAP_IR = 4'd10, S_SH_IR = 4'd11,
                         S_UPD_IR = 4'd15;

  assert_reset_ident_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR) |=> (ir == 3'b001 && !float_o));

  assert_capture_pattern_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAP_IR) |=> (ir_sh == 3'b001));

  assert_ir_held_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (state != S_UPD_IR && !(state == S_SEL_IR && tms)) |=> $stable(ir));

  assert_float_rise_R8: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(float_o) |-> ($past(state) == S_UPD_IR));

  assert_bypass_zero_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAP_DR && sel_byp) |=> !byp);

  assert_oe_window_R10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == S_SH_IR || state == S_SH_DR));
endmodule

bind scan_tap scan_tap_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir(ir),
  .ir_sh(ir_sh), .byp(byp), .sel_byp(sel_byp), .tdo_oe(tdo_oe),
  .float_o(float_o)
);

// File: tb/scan_tap_bench.sv
`timescale 1ns/1ps
module scan_tap_bench;
  localparam int          N   = 73;
  localparam logic [31:0] IDV = 32'h2F81_4093;
  localparam logic [N-1:0] P1 = {9'h1A5, 64'hDEAD_BEEF_0123_4567};
  localparam logic [N-1:0] P2 = {9'h0F3, 64'h5A5A_C3C3_9696_0FF0};

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [N-1:0] pins = P1;
  logic tdo, tdo_oe, float_o;

  int checks = 0, fails = 0;
  logic  exp_q[$];
  string tag_q[$];
  logic  last_tdo;
  bit    pending = 0;

  scan_tap #(.BSR_LEN(N), .ID_VAL(IDV)) u_scan_tap (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pins_i(pins),
    .tdo(tdo), .tdo_oe(tdo_oe), .float_o(float_o));

  always #4 tck = ~tck;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge tck) begin
    #2;
    if (tdo_oe) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected shift", {127'b0, tdo}, 128'h0);
      else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(tdo === e, t, {127'b0, tdo}, {127'b0, e});
      end
      last_tdo = tdo;
      pending  = 1;
    end
  end

  always @(posedge tck) begin
    #1;
    if (pending) begin
      pending = 0;
      chk(tdo === last_tdo && tdo_oe, "R10 tdo held over rising edge", {127'b0, tdo}, {127'b0, last_tdo});
    end
  end

  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    tms = m; tdi = d;
  endtask

  task automatic shift_ir(input logic [2:0] code);
    logic old;
    old = float_o;
    exp_q.push_back(1'b1); tag_q.push_back("R2");
    exp_q.push_back(1'b0); tag_q.push_back("R2");
    exp_q.push_back(1'b0); tag_q.push_back("R2");
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) step(i == 2, code[i]);
    step(1, 0);
    chk(float_o === old, "R4 float before update", {127'b0, float_o}, {127'b0, old});
    step(0, 0);
    @(negedge tck); #1;
  endtask

  task automatic shift_dr(input int n, input logic [127:0] din, input logic [127:0] exp, input string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp[i]);
      tag_q.push_back(req);
    end
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
    step(1, 0); step(0, 0);
    @(negedge tck); #1;
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 128'h0, 128'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge tck);
    #1;
    chk(float_o === 1'b0, "R3 reset float", {127'b0, float_o}, 128'h0);
    chk(tdo_oe === 1'b0, "R10 reset oe", {127'b0, tdo_oe}, 128'h0);
    trst_n = 1'b1;
    step(0, 0);

    shift_dr(32, 128'h0, {96'h0, IDV}, "R6 identity after reset");

    shift_ir(3'b111);
    shift_dr(8, 128'hB6, {120'h0, 7'h36, 1'b0}, "R5 bypass");

    shift_ir(3'b011);
    shift_dr(5, 128'h13, {123'h0, 4'h3, 1'b0}, "R1 reserved 011");
    shift_ir(3'b101);
    shift_dr(5, 128'h0A, {123'h0, 4'hA, 1'b0}, "R1 reserved 101");
    shift_ir(3'b110);
    shift_dr(5, 128'h1F, {123'h0, 4'hF, 1'b0}, "R1 reserved 110");

    shift_ir(3'b100);
    chk(float_o === 1'b0, "R8 sample no float", {127'b0, float_o}, 128'h0);
    shift_dr(N, {55'h0, P2}, {55'h0, P1}, "R7 sample capture");
    chk(float_o === 1'b0, "R9 float after data update", {127'b0, float_o}, 128'h0);
    pins = ~P1;
    shift_dr(N, 128'h0, {55'h0, ~P1}, "R9 no preload");

    shift_ir(3'b000);
    chk(float_o === 1'b1, "R8 extest float", {127'b0, float_o}, 128'h1);
    pins = P2;
    shift_dr(N, 128'h0, {55'h0, P2}, "R7 extest capture");
    chk(float_o === 1'b1, "R9 float kept over data update", {127'b0, float_o}, 128'h1);

    shift_ir(3'b010);
    chk(float_o === 1'b1, "R8 float-sample float", {127'b0, float_o}, 128'h1);
    pins = P1 ^ P2;
    shift_dr(N, 128'h0, {55'h0, P1 ^ P2}, "R7 float-sample capture");

    shift_ir(3'b001);
    chk(float_o === 1'b0, "R8 identity no float", {127'b0, float_o}, 128'h0);

    shift_ir(3'b000);
    for (int i = 0; i < 5; i++) step(1, 0);
    @(negedge tck); #1;
    chk(float_o === 1'b0, "R3 tms reset float", {127'b0, float_o}, 128'h0);
    step(0, 0);
    shift_dr(32, 128'h0, {96'h0, IDV}, "R3 identity after tms reset");

    shift_ir(3'b111);
    trst_n = 1'b0; #1; trst_n = 1'b1;
    step(0, 0);
    shift_dr(32, 128'h0, {96'h0, IDV}, "R3 identity after trst");

    chk(tdo_oe === 1'b0, "R10 idle oe", {127'b0, tdo_oe}, 128'h0);
    chk(exp_q.size() == 0, "R10 all bits seen", exp_q.size(), 128'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule